// File: doc/BRIEF.md
# Dual Interval Timer with Byte Register Bus

This block provides two 16-bit down-counters behind a byte-wide register bus. A host selects one of sixteen registers with address bits 12:9. It loads the counters by byte writes, reads them back byte by byte, and receives a single level interrupt when enabled timer events occur. The counters advance only on cycles where `tick_en` is high, so one tick equals one count of the timer time base.

The first timer has a 16-bit reload value. It counts down to zero, continues to all-ones, and then reloads. In one-shot mode it reports one event per load. In free-running mode it reports an event on every pass through zero. The second timer stages its low byte in a holding register. Writing its high byte loads the counter, and it reports one event per load. Per-event flags and a mask combine the events into `irq_o`. Only the first timer's flag and the (unused here) shift flag can drive that line.

Top module: `lit_timer_pair`

## Requirements
- R1: The register index is `bus_addr[12:9]`, and the other address bits are ignored. Index 4 is timer A count low, 5 is timer A count high, 6 is reload low, 7 is reload high, 8 is timer B low, 9 is timer B high, 11 is the mode byte, 13 is the flag register and 14 is the mask register. Other indices read 0x00, and writes to them have no effect.
- R2: After reset, the timer A reload value is 0xFFFF, both counters hold 0xFFFF, the timer B staged low byte is 0x00, and the mode, flags and mask are all zero.
- R3: On each tick, timer A decrements. From 0xFFFF it instead reloads the reload value, so one period is reload+2 ticks.
- R4: A timer A event (flag bit 6) occurs on the tick where the counter becomes 0. When mode bits 7:6 are not 01, only the first such tick after a load raises an event.
- R5: When mode bits 7:6 equal 01, every tick on which the counter becomes 0 raises the timer A event.
- R6: A write to index 4 or 6 changes only the reload low byte. A write to index 5 sets the reload high byte and copies the whole reload value into the counter. A write to index 7 sets only the reload high byte and leaves the counter unchanged.
- R7: A write to index 8 stores the byte in the staged low byte only. A write to index 9 loads timer B with {written byte, staged byte}. Timer B decrements on each tick, wraps without reloading, and raises flag bit 5 only on the first arrival at 0 after a load.
- R8: Flag bits: 6 is timer A, 5 is timer B and 2 is shift. Reading index 4 clears bit 6, reading index 8 clears bit 5, and writing index 13 clears the flags where the written byte has ones. An event in the same cycle as a clear wins. Reading index 13 returns {irq_o, flags[6:0]}.
- R9: A write to index 14 with bit 7 set ORs bits 6:0 into the mask. With bit 7 clear, it clears the mask bits where the written byte has ones. Reading index 14 returns {0, mask}.
- R10: `irq_o` is high exactly while (flags & mask) has bit 6 or bit 2 set. The timer B flag never drives it.
- R11: Counters change only on a tick or a load. Reads and idle cycles leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Time-base tick; advances both counters |
| bus_addr | input | 13 | Byte address; bits 12:9 select the register |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
Read data comes straight from registers, so it is due in the same cycle as the read strobe. The clearing side effect of that read lands at the closing edge. Write and tick effects appear after the edge that takes them, and `irq_o` follows one edge after the event or the mask change. The bench therefore drives each operation from one falling edge to the next, so that each operation spans exactly one rising edge, and compares results a few nanoseconds after the falling edge. Expected counter values come from counting the rising edges on which `tick_en` was high.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int REG_IDX_W = 4;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_TA_CLO = 4'd4,
    REG_TA_CHI = 4'd5,
    REG_TA_RLO = 4'd6,
    REG_TA_RHI = 4'd7,
    REG_TB_LO  = 4'd8,
    REG_TB_HI  = 4'd9,
    REG_MODE   = 4'd11,
    REG_FLAGS  = 4'd13,
    REG_MASK   = 4'd14
  } reg_idx_e;

  localparam int FLAG_TA = 6;
  localparam int FLAG_TB = 5;
  localparam int FLAG_SR = 2;
  localparam int FLAG_W  = 7;
  localparam logic [1:0] MODE_FREE_RUN = 2'b01;
endpackage

// File: rtl/lit_reload_timer.sv
module lit_reload_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             free_run,
  input  logic             wr_rld_lo,
  input  logic             wr_rld_hi,
  input  logic             wr_load_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             evt
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_d, reload_d;
  logic             armed_q, armed_d;

  always_comb begin
    reload_d = reload;
    if (wr_rld_lo)               reload_d[7:0]         = wdata;
    if (wr_rld_hi || wr_load_hi) reload_d[CNT_W-1 -: 8] = wdata;
    count_d = count;
    armed_d = armed_q;
    evt     = 1'b0;
    if (wr_load_hi) begin
      count_d = reload_d;
      armed_d = 1'b1;
    end else if (tick) begin
      count_d = (count == ALL_ONES) ? reload : count - ONE;
      evt     = (count_d == '0) && (armed_q || free_run);
      if (evt) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload  <= ALL_ONES;
      count   <= ALL_ONES;
      armed_q <= 1'b0;
    end else begin
      reload  <= reload_d;
      count   <= count_d;
      armed_q <= armed_d;
    end
  end

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_load_hi && !wr_rld_lo && !wr_rld_hi && count == ALL_ONES)
      |=> (count == $past(reload)));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_load_hi) |=> $stable(count));
  p_evt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (count == '0));
endmodule

// File: rtl/lit_oneshot_timer.sv
module lit_oneshot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] count,
  output logic             evt
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [7:0]       stage_q, stage_d;
  logic [CNT_W-1:0] count_d;
  logic             armed_q, armed_d;

  always_comb begin
    stage_d = wr_lo ? wdata : stage_q;
    count_d = count;
    armed_d = armed_q;
    evt     = 1'b0;
    if (wr_hi) begin
      count_d = CNT_W'({wdata, stage_q});
      armed_d = 1'b1;
    end else if (tick) begin
      count_d = count - ONE;
      evt     = (count_d == '0) && armed_q;
      if (evt) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 8'h00;
      count   <= ALL_ONES;
      armed_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      count   <= count_d;
      armed_q <= armed_d;
    end
  end

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (count == CNT_W'({$past(wdata), $past(stage_q)})));
  p_evt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (count == '0));
endmodule

// File: rtl/lit_irq_ctrl.sv
module lit_irq_ctrl #(
  parameter int                      FW      = 7,
  parameter logic [FW-1:0]           IRQ_SRC = 7'h44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_vec,
  input  logic [FW-1:0] clr_vec,
  input  logic          wr_mask,
  input  logic [7:0]    wdata,
  output logic [FW-1:0] flags,
  output logic [FW-1:0] mask,
  output logic          irq
);
  logic [FW-1:0] flags_d, mask_d;

  always_comb begin
    flags_d = (flags & ~clr_vec) | set_vec;
    mask_d  = mask;
    if (wr_mask) mask_d = wdata[7] ? (mask | wdata[FW-1:0]) : (mask & ~wdata[FW-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= flags_d;
      mask  <= mask_d;
    end
  end

  assign irq = |(flags & mask & IRQ_SRC);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && wdata[7]) |=> ((mask & $past(wdata[FW-1:0])) == $past(wdata[FW-1:0])));
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !wdata[7]) |=> ((mask & $past(wdata[FW-1:0])) == '0));
  p_tb_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & mask & IRQ_SRC) == '0) |-> !irq);
endmodule

// File: rtl/lit_timer_pair.sv
module lit_timer_pair #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_o
);
  import lit_pkg::*;

  localparam int IDX_LSB = ADDR_W - REG_IDX_W;
  localparam logic [FLAG_W-1:0] IRQ_SRC = FLAG_W'((1 << FLAG_TA) | (1 << FLAG_SR));

  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic [REG_IDX_W-1:0] idx;
  logic [IDX_LSB-1:0]   unused_addr_low;
  assign idx             = bus_addr[ADDR_W-1 -: REG_IDX_W];
  assign unused_addr_low = bus_addr[IDX_LSB-1:0];

  logic [7:0] mode_q, mode_d;
  always_comb mode_d = (bus_wr && idx == REG_MODE) ? bus_wdata : mode_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) mode_q <= 8'h00;
    else         mode_q <= mode_d;
  end

  logic [CNT_W-1:0] ta_count, ta_reload, tb_count;
  logic             ta_evt, tb_evt;

  lit_reload_timer #(.CNT_W(CNT_W)) u_ta (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tick      (tick_en),
    .free_run  (mode_q[7:6] == MODE_FREE_RUN),
    .wr_rld_lo (bus_wr && (idx == REG_TA_CLO || idx == REG_TA_RLO)),
    .wr_rld_hi (bus_wr && idx == REG_TA_RHI),
    .wr_load_hi(bus_wr && idx == REG_TA_CHI),
    .wdata     (bus_wdata),
    .count     (ta_count),
    .reload    (ta_reload),
    .evt       (ta_evt)
  );

  lit_oneshot_timer #(.CNT_W(CNT_W)) u_tb (
    .clk  (clk),
    .rst_n(rst_sn),
    .tick (tick_en),
    .wr_lo(bus_wr && idx == REG_TB_LO),
    .wr_hi(bus_wr && idx == REG_TB_HI),
    .wdata(bus_wdata),
    .count(tb_count),
    .evt  (tb_evt)
  );

  logic [FLAG_W-1:0] set_vec, clr_vec, flags, mask;
  always_comb begin
    set_vec          = '0;
    set_vec[FLAG_TA] = ta_evt;
    set_vec[FLAG_TB] = tb_evt;
    clr_vec          = (bus_wr && idx == REG_FLAGS) ? bus_wdata[FLAG_W-1:0] : '0;
    if (bus_rd && idx == REG_TA_CLO) clr_vec[FLAG_TA] = 1'b1;
    if (bus_rd && idx == REG_TB_LO)  clr_vec[FLAG_TB] = 1'b1;
  end

  lit_irq_ctrl #(.FW(FLAG_W), .IRQ_SRC(IRQ_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sn),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .wr_mask(bus_wr && idx == REG_MASK),
    .wdata  (bus_wdata),
    .flags  (flags),
    .mask   (mask),
    .irq    (irq_o)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (idx)
        REG_TA_CLO: bus_rdata = ta_count[7:0];
        REG_TA_CHI: bus_rdata = ta_count[CNT_W-1 -: 8];
        REG_TA_RLO: bus_rdata = ta_reload[7:0];
        REG_TA_RHI: bus_rdata = ta_reload[CNT_W-1 -: 8];
        REG_TB_LO:  bus_rdata = tb_count[7:0];
        REG_TB_HI:  bus_rdata = tb_count[CNT_W-1 -: 8];
        REG_MODE:   bus_rdata = mode_q;
        REG_FLAGS:  bus_rdata = {irq_o, flags};
        REG_MASK:   bus_rdata = {1'b0, mask};
        default:    bus_rdata = 8'h00;
      endcase
    end
  end

  p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && idx == REG_TA_CLO && !ta_evt) |=> !flags[FLAG_TA]);
endmodule

// File: tb/test_lit_timer_pair.sv
`timescale 1ns/1ps
module test_lit_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_o;
  logic        probe_irq = 1'b0;

  int total = 0;
  int bad   = 0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  lit_timer_pair i_lit_timer_pair (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Monitor: compares a few ns after each falling edge.
  always @(negedge clk) begin
    #3;
    if ((bus_rd || probe_irq) && sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {7'b0, irq_o} : bus_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    bus_addr = {idx, 9'h0C3}; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [7:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = {idx, 9'h1A5}; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    probe_irq = 1'b1;
    @(negedge clk);
    probe_irq = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    for (int k = 0; k < n; k++) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #200_000;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset values, R1 decoding with junk low address bits
    chk_irq(1'b0, "R2 irq at reset");
    rd(4'd4,  8'hFF, "R2 ta count lo");
    rd(4'd5,  8'hFF, "R2 ta count hi");
    rd(4'd6,  8'hFF, "R2 reload lo");
    rd(4'd7,  8'hFF, "R2 reload hi");
    rd(4'd8,  8'hFF, "R2 tb lo");
    rd(4'd9,  8'hFF, "R2 tb hi");
    rd(4'd11, 8'h00, "R2 mode");
    rd(4'd13, 8'h00, "R2 flags");
    rd(4'd14, 8'h00, "R2 mask");
    rd(4'd0,  8'h00, "R1 unmapped index");
    wr(4'd9, 8'h01);                          // staged low byte is 0 after reset
    rd(4'd8,  8'h00, "R2 tb staged low zero");
    rd(4'd9,  8'h01, "R7 tb high load");

    // R6 / R4 one-shot timer A
    wr(4'd4, 8'h03);
    wr(4'd5, 8'h00);
    rd(4'd6, 8'h03, "R6 reload lo");
    rd(4'd7, 8'h00, "R6 reload hi");
    rd(4'd5, 8'h00, "R6 count loaded hi");
    ticks(3);
    rd(4'd13, 8'h40, "R4 event at zero");
    rd(4'd4,  8'h00, "R4 count at zero");
    rd(4'd13, 8'h00, "R8 read clears ta flag");
    ticks(2);
    rd(4'd4, 8'h03, "R3 reload after all-ones");
    rd(4'd5, 8'h00, "R3 reload hi");
    ticks(3);
    rd(4'd13, 8'h00, "R4 one-shot no second event");

    // R6 reload-high write does not load
    wr(4'd7, 8'h12);
    rd(4'd5, 8'h00, "R6 latch-hi write no reload");
    rd(4'd7, 8'h12, "R6 reload hi updated");
    ticks(2);
    rd(4'd5, 8'h12, "R3 new reload hi");
    rd(4'd4, 8'h03, "R3 new reload lo");
    wr(4'd6, 8'h05);
    rd(4'd4, 8'h03, "R6 reload-lo write leaves count");
    rd(4'd6, 8'h05, "R6 reload lo updated");
    rd(4'd4, 8'h03, "R11 no tick no change");

    // R5 free-run, R9 mask, R10 irq
    wr(4'd11, 8'h40);
    rd(4'd11, 8'h40, "R5 mode readback");
    wr(4'd14, 8'hC0);
    rd(4'd14, 8'h40, "R9 mask set");
    wr(4'd4, 8'h01);
    wr(4'd5, 8'h00);
    ticks(1);
    chk_irq(1'b1, "R10 irq on ta event");
    rd(4'd13, 8'hC0, "R8 flags with irq bit");
    wr(4'd13, 8'h40);
    chk_irq(1'b0, "R8 write-one clears");
    ticks(2);
    rd(4'd4,  8'h01, "R3 period reload+2 midpoint");
    rd(4'd13, 8'h00, "R5 no early event");
    ticks(1);
    rd(4'd13, 8'hC0, "R5 repeated event");
    wr(4'd14, 8'h40);
    chk_irq(1'b0, "R9 mask clear drops irq");
    rd(4'd14, 8'h00, "R9 mask cleared");
    rd(4'd13, 8'h40, "R10 flag kept without irq");

    // R7 timer B, R10 timer B never drives irq
    wr(4'd11, 8'h00);
    wr(4'd13, 8'h7F);
    rd(4'd13, 8'h00, "R8 clear all");
    wr(4'd8, 8'h02);
    rd(4'd9, 8'h00, "R7 low write does not load");
    wr(4'd9, 8'h00);
    wr(4'd14, 8'hA0);
    ticks(2);
    chk_irq(1'b0, "R10 tb flag no irq");
    rd(4'd13, 8'h20, "R7 tb event");
    rd(4'd8,  8'h00, "R7 tb at zero");
    rd(4'd13, 8'h00, "R8 read clears tb flag");
    ticks(3);
    rd(4'd13, 8'h00, "R7 tb one-shot");
    rd(4'd9,  8'hFF, "R7 tb wraps hi");
    rd(4'd8,  8'hFD, "R7 tb wraps lo");
    rd(4'd8,  8'hFD, "R11 reads do not advance");
    wr(4'd0, 8'hFF);
    rd(4'd14, 8'h20, "R1 unmapped write ignored");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule